// File: doc/BRIEF.md
# Pointer and Program Counter Unit

This block keeps every address register of a small 8-bit controller core: a 15-bit program counter kept as a 7-bit upper part and an 8-bit lower part, two 8-bit data-memory pointers, and an 8-bit stack pointer. Decode logic outside the block drives it with strobes. These strobes load or step the program counter, make a data access through a chosen pointer with an optional post-increment or post-decrement, and start a subroutine call, a return or an interrupt entry.

A call or an interrupt saves the current program counter on the stack in data memory, one byte per cycle, and then jumps. Every interrupt jumps to the same vector. A return reads the two bytes back. While such a sequence is running the block asserts `busy` and owns the data-memory address. The stack pointer and both data pointers can also be read and written at fixed data-memory register addresses. The program counter cannot be reached that way.

Top module: `ptr_pc_unit`

## Requirements
- R1: After reset the program counter is 0x000, the stack pointer reads 0x2F, both data pointers read 0x00 and `busy` is low.
- R2: On an idle cycle, `pc_ld` loads `pc_ld_val`. If it is absent, `pc_step` adds one, and a carry out of the lower 8 bits goes into the upper 7 bits, wrapping modulo 2^15. A load takes precedence over a step.
- R3: An idle cycle with `ptr_acc` high puts the old value of the pointer chosen by `ptr_sel` on `dm_addr`. At the clock edge that pointer is changed by `ptr_mode`: 01 adds one, 10 subtracts one, 00 and 11 leave it unchanged. Arithmetic wraps modulo 256 and the other pointer is untouched.
- R4: `reg_rdata` shows pointer 0 at address 0xFE, pointer 1 at 0xFC, the stack pointer at 0xFD, and 0 at any other address. `reg_we` writes the addressed register. In the same cycle, a register write to a pointer wins over its post-modify.
- R5: A call pushes in two busy cycles. The first writes the lower PC byte at the stack pointer. The second writes the upper PC part, zero-extended, at the stack pointer minus 1. Each cycle decrements the stack pointer, with wrap. After the second cycle the program counter equals `call_tgt`.
- R6: An interrupt pushes the same way as R5 and then loads 0x0FF. When several requests arrive together, interrupt beats call and call beats return.
- R7: A return makes two read cycles. The first is at the stack pointer plus 1 and supplies the upper part. The second is at plus 2 and supplies the lower byte. The stack pointer ends 2 higher and the program counter equals the popped value.
- R8: While `busy` is high, the following are all ignored: new call, return and interrupt requests; `pc_ld` and `pc_step`; `ptr_acc`; and register writes to the stack pointer. During those cycles `dm_addr` carries the stack address.
- R9: `stk_we` and `stk_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_ld | input | 1 | Load program counter |
| pc_ld_val | input | 15 | Program counter load value |
| pc_step | input | 1 | Increment program counter |
| pc_out | output | 15 | Current instruction address |
| call_req | input | 1 | Start subroutine call |
| call_tgt | input | 15 | Call target address |
| ret_req | input | 1 | Start return |
| irq_req | input | 1 | Start interrupt entry |
| busy | output | 1 | Stack sequence in progress |
| ptr_acc | input | 1 | Data access through a pointer |
| ptr_sel | input | 1 | Pointer select |
| ptr_mode | input | 2 | Post-modify mode |
| dm_addr | output | 8 | Data-memory address |
| stk_we | output | 1 | Stack byte write strobe |
| stk_re | output | 1 | Stack byte read strobe |
| stk_wdata | output | 8 | Stack write byte |
| stk_rdata | input | 8 | Stack read byte, valid in the same cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench builds the unit with its default parameters: two 8-bit pointers, a 7+8 bit program counter and an 8-bit stack. Because the widths are this small, the bench can sweep every pointer value under every post-modify mode for both pointers, and every carry from the lower to the upper PC part. Calls and returns are run with many return and target addresses, in nested pairs, and with the stack pointer placed where it wraps through 0x00 and 0xFF. A byte-array stack model in the bench supplies the popped data, so return results follow only from what was pushed.

// File: rtl/ptr_pc_pkg.sv
package ptr_pc_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_PUSH_LO = 3'd1,
        SQ_PUSH_HI = 3'd2,
        SQ_POP_HI  = 3'd3,
        SQ_POP_LO  = 3'd4
    } seq_state_e;

    localparam logic [1:0] PM_HOLD = 2'b00;
    localparam logic [1:0] PM_INC  = 2'b01;
    localparam logic [1:0] PM_DEC  = 2'b10;

endpackage

// File: rtl/ptr_pc_ptr_slot.sv
module ptr_pc_ptr_slot #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    import ptr_pc_pkg::*;

    typedef struct packed {
        logic [W-1:0] val;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            slot_d.val = wdata;
        end else if (acc) begin
            case (mode)
                PM_INC:  slot_d.val = slot_q.val + W'(1);
                PM_DEC:  slot_d.val = slot_q.val - W'(1);
                default: slot_d.val = slot_q.val;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '{val: RST_VAL};
        else        slot_q <= slot_d;
    end

    assign val = slot_q.val;
endmodule

// File: rtl/ptr_pc_pc_unit.sv
module ptr_pc_pc_unit #(
    parameter int HI_W = 7,
    parameter int LO_W = 8,
    localparam int PC_W = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seq_ld,
    input  logic [PC_W-1:0] seq_val,
    input  logic            freeze,
    input  logic            ext_ld,
    input  logic [PC_W-1:0] ext_val,
    input  logic            step,
    output logic [PC_W-1:0] pc
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } pc_t;

    pc_t         pc_d, pc_q;
    logic [LO_W:0] lo_sum;

    always_comb begin
        pc_d   = pc_q;
        lo_sum = {1'b0, pc_q.lo} + (LO_W+1)'(1);
        if (seq_ld) begin
            pc_d = seq_val;
        end else if (!freeze) begin
            if (ext_ld) begin
                pc_d = ext_val;
            end else if (step) begin
                pc_d.lo = lo_sum[LO_W-1:0];
                pc_d.hi = pc_q.hi + HI_W'(lo_sum[LO_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/ptr_pc_stk_seq.sv
// Stack sequencer: owns the stack pointer and runs two-byte push/pop.
// Byte width B_W must equal LO_W and exceed HI_W.
module ptr_pc_stk_seq #(
    parameter int               HI_W    = 7,
    parameter int               LO_W    = 8,
    parameter int               B_W     = 8,
    parameter logic [B_W-1:0]   SP_RST  = 8'h2F,
    parameter logic [HI_W+LO_W-1:0] IRQ_VEC = 15'h0FF,
    localparam int              PC_W    = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    input  logic            call,
    input  logic            ret,
    input  logic [PC_W-1:0] call_tgt,
    input  logic [PC_W-1:0] pc_cur,
    input  logic            sp_we,
    input  logic [B_W-1:0]  sp_wdata,
    input  logic [B_W-1:0]  rdata,
    output logic            busy,
    output logic            start,
    output logic [B_W-1:0]  sp,
    output logic            we,
    output logic            re,
    output logic [B_W-1:0]  addr,
    output logic [B_W-1:0]  wdata,
    output logic            pc_ld,
    output logic [PC_W-1:0] pc_val
);
    import ptr_pc_pkg::*;

    typedef struct packed {
        seq_state_e      st;
        logic [B_W-1:0]  sp;
        logic [PC_W-1:0] tgt;
        logic [HI_W-1:0] hi;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [B_W-1:0] sp_up;

    always_comb begin
        seq_d  = seq_q;
        sp_up  = seq_q.sp + B_W'(1);
        we     = 1'b0;
        re     = 1'b0;
        addr   = seq_q.sp;
        wdata  = '0;
        pc_ld  = 1'b0;
        pc_val = seq_q.tgt;
        start  = 1'b0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (sp_we) seq_d.sp = sp_wdata;
                if (irq) begin
                    start     = 1'b1;
                    seq_d.st  = SQ_PUSH_LO;
                    seq_d.tgt = IRQ_VEC;
                end else if (call) begin
                    start     = 1'b1;
                    seq_d.st  = SQ_PUSH_LO;
                    seq_d.tgt = call_tgt;
                end else if (ret) begin
                    start     = 1'b1;
                    seq_d.st  = SQ_POP_HI;
                end
            end
            SQ_PUSH_LO: begin
                we       = 1'b1;
                wdata    = pc_cur[LO_W-1:0];
                seq_d.sp = seq_q.sp - B_W'(1);
                seq_d.st = SQ_PUSH_HI;
            end
            SQ_PUSH_HI: begin
                we       = 1'b1;
                wdata    = {{(B_W-HI_W){1'b0}}, pc_cur[PC_W-1:LO_W]};
                seq_d.sp = seq_q.sp - B_W'(1);
                pc_ld    = 1'b1;
                seq_d.st = SQ_IDLE;
            end
            SQ_POP_HI: begin
                re       = 1'b1;
                addr     = sp_up;
                seq_d.hi = rdata[HI_W-1:0];
                seq_d.sp = sp_up;
                seq_d.st = SQ_POP_LO;
            end
            SQ_POP_LO: begin
                re       = 1'b1;
                addr     = sp_up;
                seq_d.sp = sp_up;
                pc_ld    = 1'b1;
                pc_val   = {seq_q.hi, rdata[LO_W-1:0]};
                seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SQ_IDLE, sp: SP_RST, tgt: '0, hi: '0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.st != SQ_IDLE);
    assign sp   = seq_q.sp;
endmodule

// File: rtl/ptr_pc_unit.sv
module ptr_pc_unit #(
    parameter int                    PCH_W    = 7,
    parameter int                    PCL_W    = 8,
    parameter int                    NPTR     = 2,
    parameter int                    PTR_W    = 8,
    parameter logic [PTR_W-1:0]      SP_RST   = 8'h2F,
    parameter logic [PCH_W+PCL_W-1:0] IRQ_VEC = 15'h0FF,
    parameter logic [PTR_W-1:0]      PTR_BASE = 8'hFE,
    parameter logic [PTR_W-1:0]      SP_ADDR  = 8'hFD,
    localparam int                   PC_W     = PCH_W + PCL_W,
    localparam int                   SEL_W    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_ld,
    input  logic [PC_W-1:0]  pc_ld_val,
    input  logic             pc_step,
    output logic [PC_W-1:0]  pc_out,
    input  logic             call_req,
    input  logic [PC_W-1:0]  call_tgt,
    input  logic             ret_req,
    input  logic             irq_req,
    output logic             busy,
    input  logic             ptr_acc,
    input  logic [SEL_W-1:0] ptr_sel,
    input  logic [1:0]       ptr_mode,
    output logic [PTR_W-1:0] dm_addr,
    output logic             stk_we,
    output logic             stk_re,
    output logic [PTR_W-1:0] stk_wdata,
    input  logic [PTR_W-1:0] stk_rdata,
    input  logic             reg_we,
    input  logic [PTR_W-1:0] reg_addr,
    input  logic [PTR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0] reg_rdata
);
    logic [PTR_W-1:0] ptr_val [NPTR];
    logic [PTR_W-1:0] sp_val;
    logic [PTR_W-1:0] stk_addr;
    logic             seq_start;
    logic             seq_pc_ld;
    logic [PC_W-1:0]  seq_pc_val;
    logic             sp_we;
    logic [PTR_W-1:0] sel_ptr;

    assign sp_we = reg_we && (reg_addr == SP_ADDR);

    ptr_pc_stk_seq #(
        .HI_W(PCH_W), .LO_W(PCL_W), .B_W(PTR_W),
        .SP_RST(SP_RST), .IRQ_VEC(IRQ_VEC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .irq(irq_req), .call(call_req), .ret(ret_req),
        .call_tgt(call_tgt), .pc_cur(pc_out),
        .sp_we(sp_we), .sp_wdata(reg_wdata), .rdata(stk_rdata),
        .busy(busy), .start(seq_start), .sp(sp_val),
        .we(stk_we), .re(stk_re), .addr(stk_addr), .wdata(stk_wdata),
        .pc_ld(seq_pc_ld), .pc_val(seq_pc_val)
    );

    ptr_pc_pc_unit #(.HI_W(PCH_W), .LO_W(PCL_W)) pc_i (
        .clk(clk), .rst_n(rst_n),
        .seq_ld(seq_pc_ld), .seq_val(seq_pc_val),
        .freeze(busy | seq_start),
        .ext_ld(pc_ld), .ext_val(pc_ld_val), .step(pc_step),
        .pc(pc_out)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam logic [PTR_W-1:0] SLOT_ADDR = PTR_BASE - PTR_W'(2 * g);
        ptr_pc_ptr_slot #(.W(PTR_W), .RST_VAL('0)) slot_i (
            .clk(clk), .rst_n(rst_n),
            .acc(ptr_acc && !busy && (ptr_sel == SEL_W'(g))),
            .mode(ptr_mode),
            .wr_en(reg_we && (reg_addr == SLOT_ADDR)),
            .wdata(reg_wdata),
            .val(ptr_val[g])
        );
    end

    always_comb begin
        sel_ptr = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (ptr_sel == SEL_W'(i)) sel_ptr = ptr_val[i];
        end
    end

    assign dm_addr = busy ? stk_addr : sel_ptr;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SP_ADDR) reg_rdata = sp_val;
        for (int i = 0; i < NPTR; i++) begin
            if (reg_addr == PTR_BASE - PTR_W'(2 * i)) reg_rdata = ptr_val[i];
        end
    end
endmodule

// File: rtl/ptr_pc_chk.sv
module ptr_pc_chk #(
    parameter int PC_W  = 15,
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             stk_we,
    input logic             stk_re,
    input logic [PTR_W-1:0] dm_addr,
    input logic [PC_W-1:0]  pc_out,
    input logic             pc_ld,
    input logic             pc_step,
    input logic             call_req,
    input logic             ret_req,
    input logic             irq_req
);
    AST_STK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!stk_we && !stk_re)); // R9

    AST_PUSH_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (dm_addr == PTR_W'($past(dm_addr) - PTR_W'(1)))); // R5

    AST_POP_ASC: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_re && $past(stk_re)) |-> (dm_addr == PTR_W'($past(dm_addr) + PTR_W'(1)))); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !call_req && !ret_req && !irq_req && !pc_ld && pc_step)
        |=> (pc_out == PC_W'($past(pc_out) + PC_W'(1)))); // R2

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $stable(pc_out)); // R8
endmodule

bind ptr_pc_unit ptr_pc_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .stk_we(stk_we), .stk_re(stk_re),
    .dm_addr(dm_addr), .pc_out(pc_out), .pc_ld(pc_ld), .pc_step(pc_step),
    .call_req(call_req), .ret_req(ret_req), .irq_req(irq_req)
);

// File: tb/ptr_pc_unit_tb_top.sv
`timescale 1ns/100ps
module ptr_pc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_ld = 1'b0;
    logic [14:0] pc_ld_val = '0;
    logic        pc_step = 1'b0;
    logic [14:0] pc_out;
    logic        call_req = 1'b0;
    logic [14:0] call_tgt = '0;
    logic        ret_req = 1'b0;
    logic        irq_req = 1'b0;
    logic        busy;
    logic        ptr_acc = 1'b0;
    logic [0:0]  ptr_sel = '0;
    logic [1:0]  ptr_mode = '0;
    logic [7:0]  dm_addr;
    logic        stk_we, stk_re;
    logic [7:0]  stk_wdata;
    logic [7:0]  stk_rdata;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] mem [256];
    logic [7:0] exp_ptr [2];
    logic [7:0] exp_sp;

    always #2.5 clk = ~clk;

    ptr_pc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
        .pc_step(pc_step), .pc_out(pc_out), .call_req(call_req),
        .call_tgt(call_tgt), .ret_req(ret_req), .irq_req(irq_req),
        .busy(busy), .ptr_acc(ptr_acc), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode),
        .dm_addr(dm_addr), .stk_we(stk_we), .stk_re(stk_re),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (stk_we) mem[dm_addr] <= stk_wdata;
    assign stk_rdata = mem[dm_addr];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic settle(); #0.2; endtask
    task automatic edge_pass(); @(negedge clk); endtask

    task automatic clear_in();
        pc_ld = 0; pc_step = 0; call_req = 0; ret_req = 0; irq_req = 0;
        ptr_acc = 0; reg_we = 0; ptr_mode = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] e);
        reg_addr = a; settle();
        chk(req, "reg_rdata", {24'd0, reg_rdata}, {24'd0, e});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        edge_pass(); reg_we = 0;
        if (a == 8'hFE) exp_ptr[0] = d;
        if (a == 8'hFC) exp_ptr[1] = d;
        if (a == 8'hFD) exp_sp = d;
    endtask

    task automatic load_pc(input logic [14:0] v);
        pc_ld = 1; pc_ld_val = v; edge_pass(); pc_ld = 0;
    endtask

    // kind 0 = call, 1 = interrupt; noisy drives ignored inputs in the first busy cycle
    task automatic do_push(input int kind, input logic [14:0] tgt, input bit noisy,
                           input string req);
        logic [14:0] p;
        logic [7:0]  s;
        logic [14:0] e_pc;
        p = pc_out; s = exp_sp;
        e_pc = (kind == 1) ? 15'h0FF : tgt;
        if (kind == 1) irq_req = 1; else begin call_req = 1; call_tgt = tgt; end
        edge_pass(); clear_in();
        settle();
        chk(req, "busy A", {31'd0, busy}, 32'd1);
        chk(req, "we/re A", {30'd0, stk_we, stk_re}, 32'd2);
        chk(req, "addr A", {24'd0, dm_addr}, {24'd0, s});
        chk(req, "byte lo", {24'd0, stk_wdata}, {24'd0, p[7:0]});
        if (noisy) begin
            pc_step = 1; pc_ld = 1; pc_ld_val = 15'h1234; ptr_acc = 1; ptr_sel = 0;
            ptr_mode = 2'b01; reg_we = 1; reg_addr = 8'hFD; reg_wdata = 8'h77;
            ret_req = 1; irq_req = 1; call_req = 1;
            settle();
            chk("R8", "addr under noise", {24'd0, dm_addr}, {24'd0, s});
        end
        edge_pass(); clear_in();
        settle();
        chk(req, "we B", {31'd0, stk_we}, 32'd1);
        chk(req, "addr B", {24'd0, dm_addr}, {24'd0, 8'(s - 8'd1)});
        chk(req, "byte hi", {24'd0, stk_wdata}, {24'd0, 1'b0, p[14:8]});
        edge_pass();
        exp_sp = 8'(s - 8'd2);
        settle();
        chk(req, "busy end", {31'd0, busy}, 32'd0);
        chk(req, "pc after push", {17'd0, pc_out}, {17'd0, e_pc});
        rd_chk(req, 8'hFD, exp_sp);
        if (noisy) begin
            chk("R8", "pc after noise", {17'd0, pc_out}, {17'd0, e_pc});
            rd_chk("R8", 8'hFE, exp_ptr[0]);
        end
    endtask

    task automatic do_ret(input logic [14:0] e_pc);
        logic [7:0] s;
        s = exp_sp;
        ret_req = 1; edge_pass(); clear_in();
        settle();
        chk("R7", "we/re A", {30'd0, stk_we, stk_re}, 32'd1);
        chk("R7", "addr A", {24'd0, dm_addr}, {24'd0, 8'(s + 8'd1)});
        edge_pass(); settle();
        chk("R7", "re B", {31'd0, stk_re}, 32'd1);
        chk("R7", "addr B", {24'd0, dm_addr}, {24'd0, 8'(s + 8'd2)});
        edge_pass();
        exp_sp = 8'(s + 8'd2);
        settle();
        chk("R7", "busy end", {31'd0, busy}, 32'd0);
        chk("R7", "pc popped", {17'd0, pc_out}, {17'd0, e_pc});
        rd_chk("R7", 8'hFD, exp_sp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        exp_ptr[0] = 0; exp_ptr[1] = 0; exp_sp = 8'h2F;
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        // R1 reset state
        chk("R1", "pc", {17'd0, pc_out}, 32'd0);
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        rd_chk("R1", 8'hFD, 8'h2F);
        rd_chk("R1", 8'hFE, 8'h00);
        rd_chk("R1", 8'hFC, 8'h00);
        edge_pass();
        rd_chk("R4", 8'hFB, 8'h00);
        rd_chk("R4", 8'h2F, 8'h00);

        // R3/R4: full pointer value x mode sweep on both pointers
        for (int sel = 0; sel < 2; sel++) begin
            for (int v = 0; v < 256; v++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] nv;
                    wr_reg(sel == 0 ? 8'hFE : 8'hFC, 8'(v));
                    ptr_acc = 1; ptr_sel = 1'(sel); ptr_mode = 2'(m);
                    settle();
                    chk("R3", "old value on dm_addr", {24'd0, dm_addr}, v);
                    edge_pass(); clear_in();
                    nv = (m == 1) ? 8'(v + 1) : (m == 2) ? 8'(v - 1) : 8'(v);
                    exp_ptr[sel] = nv;
                    rd_chk("R3", 8'hFE, exp_ptr[0]);
                    rd_chk("R3", 8'hFC, exp_ptr[1]);
                end
            end
        end

        // R4: register write beats post-modify
        wr_reg(8'hFE, 8'h10);
        reg_we = 1; reg_addr = 8'hFE; reg_wdata = 8'h55;
        ptr_acc = 1; ptr_sel = 0; ptr_mode = 2'b01;
        edge_pass(); clear_in(); exp_ptr[0] = 8'h55;
        rd_chk("R4", 8'hFE, 8'h55);

        // R2: carries from every upper value, then lower-byte sweep
        for (int i = 0; i < 128; i++) begin
            load_pc({7'(i), 8'hFF});
            pc_step = 1; edge_pass(); pc_step = 0; settle();
            chk("R2", "carry", {17'd0, pc_out}, {17'd0, 15'(((i + 1) % 128) * 256)});
        end
        for (int j = 0; j < 256; j++) begin
            load_pc({7'h15, 8'(j)});
            settle();
            chk("R2", "load", {17'd0, pc_out}, {17'd0, 7'h15, 8'(j)});
            pc_step = 1; edge_pass(); pc_step = 0; settle();
            chk("R2", "step", {17'd0, pc_out}, {17'd0, 15'({7'h15, 8'(j)} + 1)});
        end
        pc_ld = 1; pc_ld_val = 15'h2AB; pc_step = 1; edge_pass(); clear_in(); settle();
        chk("R2", "load over step", {17'd0, pc_out}, 32'h2AB);

        // R5/R7: many call/return pairs, then nested
        for (int k = 0; k < 32; k++) begin
            logic [14:0] p;
            p = 15'(k * 1021 + 3);
            load_pc(p);
            do_push(0, 15'(k * 7919), 1'b0, "R5");
            do_ret(p);
        end
        load_pc(15'h0123);
        do_push(0, 15'h4567, 1'b0, "R5");
        do_push(0, 15'h7ABC, 1'b0, "R5");
        do_ret(15'h4567);
        do_ret(15'h0123);

        // R8: ignored inputs during the busy window
        load_pc(15'h3C5A);
        do_push(0, 15'h0777, 1'b1, "R8");
        do_ret(15'h3C5A);

        // R6: interrupt vector and request priority
        load_pc(15'h5A5A);
        irq_req = 1; call_req = 1; ret_req = 1; call_tgt = 15'h1111;
        do_push(1, 15'h0, 1'b0, "R6");
        do_ret(15'h5A5A);
        load_pc(15'h0042);
        ret_req = 1;
        do_push(0, 15'h2222, 1'b0, "R6");
        chk("R6", "call over return", {17'd0, pc_out}, 32'h2222);
        do_ret(15'h0042);

        // R5/R7: stack pointer wrap through 0x00/0xFF
        wr_reg(8'hFD, 8'h01);
        load_pc(15'h6E01);
        do_push(0, 15'h0100, 1'b0, "R5");
        do_ret(15'h6E01);
        wr_reg(8'hFD, 8'h00);
        load_pc(15'h1F80);
        do_push(1, 15'h0, 1'b0, "R6");
        do_ret(15'h1F80);
        rd_chk("R5", 8'hFD, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule